// File: doc/BRIEF.md
# Strobe-Addressed Control Status Register

A 16-bit system control and status register for a byte-addressed bus, in which every change to a bit is made by writing to an address. The data of a write is never looked at. Each firmware-controlled bit has one address that sets it and another that clears it. Four status bits are set by hardware event inputs: bus timeout, parity error, alignment fault and the interval-clock tick. Firmware acknowledges these bits through their clear addresses. The whole register is also driven out as `csr_o`, so that the LED, the floppy motor, the programmed interrupt requests and the inhibit controls can reach their consumers.

Two write addresses produce side-effect pulses and do not store anything new. One write requests a full system reset. Clearing the timer-inhibit bit also emits a one-cycle force-tick toward the interval timer, which moves every gated and enabled counter to its divider minus one. Reads return either one byte or the whole halfword, selected by the offset and the access size.

Top module: `strobe_csr`

## Requirements
- R1: After reset, `csr_o` is 0x0000, `sys_reset_req_o` and `force_tick_o` are low, and `rd_data_o` is 0.
- R2: A write (`wr_en_i` high) updates the register at the next rising clock edge, according to the write offset:
  - failure LED, bit 4: offset 0x13 sets it and 0x17 clears it.
  - floppy motor, bit 6: offset 0x1B sets it and 0x1F clears it.
  - timer inhibit, bit 7: offset 0x23 sets it and 0x27 clears it.
  - fault inhibit, bit 8: offset 0x2B sets it and 0x2F clears it.
  - PIR9, bit 11: offset 0x33 sets it and 0x37 clears it.
  - PIR8, bit 10: offset 0x3B sets it and 0x3F clears it.
- R3: Three error bits are each set by an event input and cleared by a write:
  - bus timeout, bit 0: set by `bus_timeout_i`, cleared by a write to 0x03.
  - parity error, bit 1: set by `parity_err_i`, cleared by a write to 0x07.
  - alignment fault, bit 3: set by `align_fault_i`, cleared by a write to 0x0F.
  
  When an event and the matching clear arrive in the same cycle, the bit is left set.
- R4: The clock bit (bit 9) is set by `clk_tick_i` only when the timer-inhibit bit was 0 before that edge. A tick has no effect while the inhibit bit is 1. `clk_clear_i` clears bit 9, but a tick in the same cycle wins and leaves the bit set.
- R5: A write to offset 0x0B drives `sys_reset_req_o` high for the one cycle after the write edge, and it leaves the register unchanged.
- R6: Every write to offset 0x27 drives `force_tick_o` high for the one cycle after the write edge.
- R7: Writes to any other address, including any address with a bit set above bit 5, change nothing. Bits 15:12, 5 and 2 always read 0.
- R8: While `rd_en_i` is high, `rd_data_o` is driven as follows:
  - offset 0x02 with `rd_hw_i` high: the whole register.
  - offset 0x02 with `rd_hw_i` low: {8'h00, bits 15:8}.
  - offset 0x03: {8'h00, bits 7:0}.
  - any other address: 0.
  
  While `rd_en_i` is low, `rd_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe; acts on the address only |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Byte offset within the block |
| rd_hw_i | input | 1 | Read size: 1 = halfword, 0 = byte |
| bus_timeout_i | input | 1 | Bus timeout event |
| parity_err_i | input | 1 | Memory parity error event |
| align_fault_i | input | 1 | Alignment fault event |
| clk_tick_i | input | 1 | Interval clock tick |
| clk_clear_i | input | 1 | Clock-bit acknowledge from the timer |
| rd_data_o | output | 16 | Read data |
| csr_o | output | 16 | Current register contents |
| sys_reset_req_o | output | 1 | One-cycle system reset request |
| force_tick_o | output | 1 | One-cycle force-tick toward the timers |

## Verification
Read data is combinational, so it is due in the same cycle as `rd_en_i`. Register bits and the two pulses are due at the rising edge that samples the write or event. The bench drives inputs at the falling edge and checks `rd_data_o` one nanosecond later, against the model state from before that edge. After the next rising edge, it advances the model with the same inputs and compares `csr_o` and both pulses one nanosecond past that edge. The pulse is compared as low in every cycle that has no triggering write, so a pulse held too long is caught.

// File: rtl/strobe_csr_pkg.sv
package strobe_csr_pkg;
  localparam int CSR_W = 16;
  localparam int OFF_W = 6;

  localparam int B_TIMO = 0;
  localparam int B_PARE = 1;
  localparam int B_ALGN = 3;
  localparam int B_LED  = 4;
  localparam int B_FLOP = 6;
  localparam int B_ITIM = 7;
  localparam int B_IFLT = 8;
  localparam int B_CLK  = 9;
  localparam int B_PIR8 = 10;
  localparam int B_PIR9 = 11;

  localparam logic [CSR_W-1:0] IMPL_MASK = 16'h0FDB;

  localparam logic [OFF_W-1:0] OFF_RD_HI     = 6'h02;
  localparam logic [OFF_W-1:0] OFF_RD_LO     = 6'h03;
  localparam logic [OFF_W-1:0] OFF_CLR_TIMO  = 6'h03;
  localparam logic [OFF_W-1:0] OFF_CLR_PARE  = 6'h07;
  localparam logic [OFF_W-1:0] OFF_SYS_RST   = 6'h0B;
  localparam logic [OFF_W-1:0] OFF_CLR_ALGN  = 6'h0F;
  localparam logic [OFF_W-1:0] OFF_SET_LED   = 6'h13;
  localparam logic [OFF_W-1:0] OFF_CLR_LED   = 6'h17;
  localparam logic [OFF_W-1:0] OFF_SET_FLOP  = 6'h1B;
  localparam logic [OFF_W-1:0] OFF_CLR_FLOP  = 6'h1F;
  localparam logic [OFF_W-1:0] OFF_SET_ITIM  = 6'h23;
  localparam logic [OFF_W-1:0] OFF_CLR_ITIM  = 6'h27;
  localparam logic [OFF_W-1:0] OFF_SET_IFLT  = 6'h2B;
  localparam logic [OFF_W-1:0] OFF_CLR_IFLT  = 6'h2F;
  localparam logic [OFF_W-1:0] OFF_SET_PIR9  = 6'h33;
  localparam logic [OFF_W-1:0] OFF_CLR_PIR9  = 6'h37;
  localparam logic [OFF_W-1:0] OFF_SET_PIR8  = 6'h3B;
  localparam logic [OFF_W-1:0] OFF_CLR_PIR8  = 6'h3F;

  typedef struct packed {
    logic [CSR_W-1:0] set;
    logic [CSR_W-1:0] clr;
    logic             rst_req;
    logic             force_tick;
  } wr_dec_t;
endpackage

// File: rtl/strobe_csr_bit.sv
module strobe_csr_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hw_set_i,
  input  logic sw_set_i,
  input  logic sw_clr_i,
  output logic q_o
);
  // hardware event outranks a firmware clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= 1'b0;
    else if (hw_set_i) q_o <= 1'b1;
    else if (sw_clr_i) q_o <= 1'b0;
    else if (sw_set_i) q_o <= 1'b1;
  end
endmodule

// File: rtl/strobe_csr_dec.sv
module strobe_csr_dec
  import strobe_csr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wr_dec_t           dec_o
);
  logic             in_range;
  logic [OFF_W-1:0] off;

  assign in_range = (addr_i >> OFF_W) == '0;
  assign off      = addr_i[OFF_W-1:0];

  always_comb begin
    dec_o = '0;
    if (wr_en_i && in_range) begin
      unique case (off)
        OFF_CLR_TIMO: dec_o.clr[B_TIMO] = 1'b1;
        OFF_CLR_PARE: dec_o.clr[B_PARE] = 1'b1;
        OFF_SYS_RST:  dec_o.rst_req     = 1'b1;
        OFF_CLR_ALGN: dec_o.clr[B_ALGN] = 1'b1;
        OFF_SET_LED:  dec_o.set[B_LED]  = 1'b1;
        OFF_CLR_LED:  dec_o.clr[B_LED]  = 1'b1;
        OFF_SET_FLOP: dec_o.set[B_FLOP] = 1'b1;
        OFF_CLR_FLOP: dec_o.clr[B_FLOP] = 1'b1;
        OFF_SET_ITIM: dec_o.set[B_ITIM] = 1'b1;
        OFF_CLR_ITIM: begin
          dec_o.clr[B_ITIM] = 1'b1;
          dec_o.force_tick  = 1'b1;
        end
        OFF_SET_IFLT: dec_o.set[B_IFLT] = 1'b1;
        OFF_CLR_IFLT: dec_o.clr[B_IFLT] = 1'b1;
        OFF_SET_PIR9: dec_o.set[B_PIR9] = 1'b1;
        OFF_CLR_PIR9: dec_o.clr[B_PIR9] = 1'b1;
        OFF_SET_PIR8: dec_o.set[B_PIR8] = 1'b1;
        OFF_CLR_PIR8: dec_o.clr[B_PIR8] = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/strobe_csr_rd.sv
module strobe_csr_rd
  import strobe_csr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_hw_i,
  input  logic [CSR_W-1:0]  csr_i,
  output logic [CSR_W-1:0]  data_o
);
  localparam int BYTE_W = CSR_W / 2;

  logic             in_range;
  logic [OFF_W-1:0] off;

  assign in_range = (addr_i >> OFF_W) == '0;
  assign off      = addr_i[OFF_W-1:0];

  always_comb begin
    data_o = '0;
    if (rd_en_i && in_range) begin
      if (off == OFF_RD_HI)
        data_o = rd_hw_i ? csr_i : {{BYTE_W{1'b0}}, csr_i[CSR_W-1:BYTE_W]};
      else if (off == OFF_RD_LO)
        data_o = {{BYTE_W{1'b0}}, csr_i[BYTE_W-1:0]};
    end
  end
endmodule

// File: rtl/strobe_csr.sv
module strobe_csr
  import strobe_csr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_hw_i,
  input  logic              bus_timeout_i,
  input  logic              parity_err_i,
  input  logic              align_fault_i,
  input  logic              clk_tick_i,
  input  logic              clk_clear_i,
  output logic [15:0]       rd_data_o,
  output logic [15:0]       csr_o,
  output logic              sys_reset_req_o,
  output logic              force_tick_o
);
  wr_dec_t          dec;
  logic [CSR_W-1:0] csr_q;
  logic [CSR_W-1:0] hw_set;
  logic [CSR_W-1:0] clr_all;

  strobe_csr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .dec_o   (dec)
  );

  always_comb begin
    hw_set         = '0;
    hw_set[B_TIMO] = bus_timeout_i;
    hw_set[B_PARE] = parity_err_i;
    hw_set[B_ALGN] = align_fault_i;
    hw_set[B_CLK]  = clk_tick_i & ~csr_q[B_ITIM];
    clr_all        = dec.clr;
    clr_all[B_CLK] = clk_clear_i;
  end

  for (genvar i = 0; i < CSR_W; i++) begin : g_bit
    strobe_csr_bit u_bit (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .hw_set_i (hw_set[i]),
      .sw_set_i (dec.set[i]),
      .sw_clr_i (clr_all[i]),
      .q_o      (csr_q[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sys_reset_req_o <= 1'b0;
      force_tick_o    <= 1'b0;
    end else begin
      sys_reset_req_o <= dec.rst_req;
      force_tick_o    <= dec.force_tick;
    end
  end

  strobe_csr_rd #(.ADDR_W(ADDR_W)) u_rd (
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .rd_hw_i (rd_hw_i),
    .csr_i   (csr_q),
    .data_o  (rd_data_o)
  );

  assign csr_o = csr_q;
endmodule

// File: rtl/strobe_csr_chk.sv
module strobe_csr_chk
  import strobe_csr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              bus_timeout_i,
  input logic              clk_tick_i,
  input logic              clk_clear_i,
  input logic [15:0]       csr_o,
  input logic              sys_reset_req_o,
  input logic              force_tick_o
);
  // R3
  timo_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_timeout_i |=> csr_o[B_TIMO]);
  // R3
  timo_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(3) && !bus_timeout_i) |=> !csr_o[B_TIMO]);
  // R4
  clk_inhibit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_o[B_ITIM] && !csr_o[B_CLK]) |=> !csr_o[B_CLK]);
  // R4
  clk_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_clear_i && !clk_tick_i) |=> !csr_o[B_CLK]);
  // R5
  rst_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(11)) |=> sys_reset_req_o);
  // R5
  rst_req_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_reset_req_o |-> $past(wr_en_i && addr_i == ADDR_W'(11)));
  // R6
  tick_itim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_tick_o |-> !csr_o[B_ITIM]);
  // R7
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_o & ~IMPL_MASK) == 16'h0000);
endmodule

bind strobe_csr strobe_csr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .wr_en_i         (wr_en_i),
  .addr_i          (addr_i),
  .bus_timeout_i   (bus_timeout_i),
  .clk_tick_i      (clk_tick_i),
  .clk_clear_i     (clk_clear_i),
  .csr_o           (csr_o),
  .sys_reset_req_o (sys_reset_req_o),
  .force_tick_o    (force_tick_o)
);

// File: tb/strobe_csr_tb.sv
module strobe_csr_tb;
  localparam int AW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0, rd_en_i = 1'b0, rd_hw_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          bus_timeout_i = 1'b0, parity_err_i = 1'b0, align_fault_i = 1'b0;
  logic          clk_tick_i = 1'b0, clk_clear_i = 1'b0;
  logic [15:0]   rd_data_o, csr_o;
  logic          sys_reset_req_o, force_tick_o;

  int total = 0;
  int fails = 0;
  logic [15:0] exp_csr = '0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  strobe_csr #(.ADDR_W(AW)) u_dut (.*);

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model_next(logic [15:0] cur, logic wr, logic [AW-1:0] a,
      logic bt, logic pe, logic af, logic tick, logic cclr);
    logic [15:0] n = cur;
    if (wr) begin
      case (a)
        8'h03: n[0] = 1'b0;   8'h07: n[1] = 1'b0;   8'h0F: n[3] = 1'b0;
        8'h13: n[4] = 1'b1;   8'h17: n[4] = 1'b0;
        8'h1B: n[6] = 1'b1;   8'h1F: n[6] = 1'b0;
        8'h23: n[7] = 1'b1;   8'h27: n[7] = 1'b0;
        8'h2B: n[8] = 1'b1;   8'h2F: n[8] = 1'b0;
        8'h33: n[11] = 1'b1;  8'h37: n[11] = 1'b0;
        8'h3B: n[10] = 1'b1;  8'h3F: n[10] = 1'b0;
        default: ;
      endcase
    end
    if (cclr) n[9] = 1'b0;
    if (bt) n[0] = 1'b1;
    if (pe) n[1] = 1'b1;
    if (af) n[3] = 1'b1;
    if (tick && !cur[7]) n[9] = 1'b1;
    return n;
  endfunction

  function automatic logic [15:0] model_rd(logic [15:0] c, logic rd, logic [AW-1:0] a, logic hw);
    if (!rd) return 16'h0;
    if (a == 8'h02) return hw ? c : {8'h00, c[15:8]};
    if (a == 8'h03) return {8'h00, c[7:0]};
    return 16'h0;
  endfunction

  task automatic cyc(logic wr, logic rd, logic [AW-1:0] a, logic hw,
      logic bt = 0, logic pe = 0, logic af = 0, logic tick = 0, logic cclr = 0);
    @(negedge clk_i);
    wr_en_i = wr; rd_en_i = rd; addr_i = a; rd_hw_i = hw;
    bus_timeout_i = bt; parity_err_i = pe; align_fault_i = af;
    clk_tick_i = tick; clk_clear_i = cclr;
    #1;
    chk("R8 read data", rd_data_o, model_rd(exp_csr, rd, a, hw));
    @(posedge clk_i);
    #1;
    exp_csr = model_next(exp_csr, wr, a, bt, pe, af, tick, cclr);
    chk("R2 R3 R4 R7 register", csr_o, exp_csr);
    chk("R5 reset request", {15'h0, sys_reset_req_o}, {15'h0, wr && a == 8'h0B});
    chk("R6 force tick", {15'h0, force_tick_o}, {15'h0, wr && a == 8'h27});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1789));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R1
    chk("R1 reset csr", csr_o, 16'h0);
    chk("R1 reset pulses", {14'h0, sys_reset_req_o, force_tick_o}, 16'h0);
    chk("R1 reset rd", rd_data_o, 16'h0);

    // R2 / R8: set LED and PIR9, read back in each form
    cyc(1, 0, 8'h13, 0);
    cyc(0, 1, 8'h03, 0);
    cyc(0, 1, 8'h02, 1);
    cyc(1, 0, 8'h33, 0);
    cyc(0, 1, 8'h02, 0);
    cyc(0, 1, 8'h00, 1);
    cyc(0, 1, 8'h42, 1);
    // R3: event wins over clear in the same cycle
    cyc(1, 0, 8'h03, 0, 1);
    cyc(1, 0, 8'h03, 0);
    cyc(1, 0, 8'h07, 0, 0, 1);
    cyc(1, 0, 8'h0F, 0, 0, 0, 1);
    // R7: out-of-range alias of a clear address
    cyc(0, 0, 8'h00, 0, 0, 0, 1);
    cyc(1, 0, 8'h4F, 0);
    cyc(1, 0, 8'h0E, 0);
    // R4 / R6: inhibit blocks tick, clearing pulses force tick
    cyc(1, 0, 8'h23, 0);
    cyc(0, 0, 8'h00, 0, 0, 0, 0, 1);
    cyc(1, 0, 8'h27, 0);
    cyc(0, 0, 8'h00, 0);
    cyc(0, 0, 8'h00, 0, 0, 0, 0, 1);
    cyc(0, 0, 8'h00, 0, 0, 0, 0, 1, 1);
    cyc(0, 0, 8'h00, 0, 0, 0, 0, 0, 1);
    cyc(1, 0, 8'h27, 0);
    cyc(1, 0, 8'h27, 0);
    // R5: reset request pulse, register untouched
    cyc(1, 0, 8'h0B, 0);
    cyc(0, 0, 8'h00, 0);

    for (int n = 0; n < 1500; n++) begin
      logic [AW-1:0] a;
      a = ($urandom % 5 == 0) ? AW'($urandom % 256) : {2'b00, 4'($urandom), 2'b11};
      if ($urandom % 6 == 0) a = {6'h0, 1'b1, 1'($urandom)};
      cyc(1'($urandom), 1'($urandom), a, 1'($urandom),
          $urandom % 9 == 0, $urandom % 9 == 0, $urandom % 9 == 0,
          $urandom % 4 == 0, $urandom % 5 == 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule